// File: doc/BRIEF.md
# Multiplexed Local Bus Target

This block connects a bridge's 32-bit local bus, on which address and data share the same wires, to a simple internal word port. It acts only as a target and never starts a transaction of its own. A transaction opens with one cycle in which the active-low strobe is low and the shared bus carries the start address. The block latches that address with its two low bits cleared, and also latches the direction. Every cycle after that is a data cycle. The target paces the data cycles with its active-low ready output.

A write beat completes in any cycle where ready is low. In that same cycle the block passes the bus word, the lane mask and the current address to the internal port. A read beat also completes in a cycle where ready is low. In that cycle the block drives the internal port's read word onto the bus. Before the first read beat, the block holds ready high for a parameterised number of cycles to cover the internal read latency. Later beats of the burst follow with no wait cycles.

After each completed beat, the block advances its own address by one word. This happens because the bus presents no further addresses during a burst. The beat on which the active-low last marker is low ends the transaction, and the block returns to idle.

Top module: `mlb_target`

## Requirements
- R1: After reset the target is idle: ready is high, the bus output enable is low, and no internal read or write is requested.
- R2: The address is taken only in the cycle where the strobe is low while idle, and its two low bits are forced to zero. While idle with the strobe high, bus activity starts nothing and causes no internal request.
- R3: A write beat is a data cycle of a write transaction in which ready is low. In that same cycle the internal write strobe is high, and the write data equals the bus word. The lane mask equals the bitwise inverse of the active-low byte enables, where bit k covers bus bits 8k+7..8k.
- R4: A beat completes only in a cycle where ready is low. After each completed beat that is not the last, the internal address rises by 4.
- R5: The beat with last low completes the transaction. In the following cycle ready is high and the target accepts a new strobe.
- R6: In a read, ready stays high for exactly WAIT_RD cycles after the strobe cycle before the first beat. Later beats of the same burst have no wait cycles. Writes have no wait cycles.
- R7: The bus output enable is high only in read beats. It is low in the address cycle, in wait cycles, in all write cycles and while idle.
- R8: In a read beat, the internal read strobe is high and the bus output carries the internal read word for the current address.
- R9: A low strobe during an active transaction is ignored: the address sequence of the burst continues linearly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local bus clock |
| rst | input | 1 | Synchronous active-high reset |
| lb_ad_in | input | 32 | Shared address/data bus as seen by the target |
| lb_ad_out | output | 32 | Read data driven toward the shared bus |
| lb_ad_oe | output | 1 | Output enable for lb_ad_out |
| lb_be_n | input | 4 | Active-low byte lane enables |
| lb_strobe_n | input | 1 | Active-low address strobe |
| lb_last_n | input | 1 | Active-low last-beat marker |
| lb_write | input | 1 | Direction, 1 = write, 0 = read, sampled with the strobe |
| lb_ready_n | output | 1 | Active-low beat ready from the target |
| mem_we | output | 1 | Internal write strobe |
| mem_re | output | 1 | Internal read strobe |
| mem_addr | output | 32 | Internal word address (byte address, low bits zero) |
| mem_wdata | output | 32 | Internal write data |
| mem_be | output | 4 | Internal active-high lane mask |
| mem_rdata | input | 32 | Internal read data, valid in the cycle mem_re is high |

## Verification
Several properties are checked on every cycle. The output enable and the internal strobes appear only while ready is low. Read and write strobes are never high together. Every non-final beat advances the address by one word, and a last beat always brings ready back high the next cycle. Only a read transaction ever passes through a wait cycle. Other behaviours need the bench's scenarios, which track each transaction against a reference memory. These are the exact count of wait cycles before the first read beat, the alignment of the latched address, stray strobes in the middle of a burst, lane-masked writes, and read data that reflects earlier writes.

// File: rtl/mlb_pkg.sv
package mlb_pkg;

    localparam int unsigned MLB_DW  = 32;
    localparam int unsigned MLB_BE  = MLB_DW / 8;
    localparam int unsigned MLB_OFS = $clog2(MLB_BE);

    typedef logic [MLB_DW-1:0] mlb_word_t;
    typedef logic [MLB_BE-1:0] mlb_lane_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_BEAT = 2'd2
    } mlb_state_e;

    typedef struct packed {
        logic      we;
        logic      re;
        mlb_word_t addr;
        mlb_word_t wdata;
        mlb_lane_t be;
    } mlb_req_t;

    function automatic mlb_word_t align_word(input mlb_word_t a);
        return {a[MLB_DW-1:MLB_OFS], {MLB_OFS{1'b0}}};
    endfunction

    function automatic mlb_word_t next_word(input mlb_word_t a);
        return a + mlb_word_t'(MLB_BE);
    endfunction

endpackage

// File: rtl/mlb_seq.sv
module mlb_seq
    import mlb_pkg::*;
#(
    parameter int unsigned WAIT_RD = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_n,
    input  logic wr_dir,
    input  logic last_n,
    output logic load,
    output logic beat,
    output logic ready_n,
    output logic dir_wr
);

    localparam int unsigned CW = (WAIT_RD > 1) ? $clog2(WAIT_RD) : 1;

    mlb_state_e state_q;
    logic       wait_done;

    assign load    = (state_q == ST_IDLE) && !strobe_n;
    assign beat    = (state_q == ST_BEAT);
    assign ready_n = !beat;

    generate
        if (WAIT_RD == 0) begin : g_nowait
            assign wait_done = 1'b1;
        end else begin : g_wait
            localparam logic [CW-1:0] CNT_INIT = CW'(WAIT_RD - 1);
            logic [CW-1:0] cnt_q;
            always_ff @(posedge clk) begin
                if (rst)
                    cnt_q <= '0;
                else if (load)
                    cnt_q <= CNT_INIT;
                else if (state_q == ST_WAIT && cnt_q != '0)
                    cnt_q <= cnt_q - 1'b1;
            end
            assign wait_done = (cnt_q == '0);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            dir_wr  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (load) begin
                    dir_wr  <= wr_dir;
                    state_q <= (wr_dir || WAIT_RD == 0) ? ST_BEAT : ST_WAIT;
                end
                ST_WAIT: if (wait_done) state_q <= ST_BEAT;
                ST_BEAT: if (!last_n) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R6
    rd_wait_only_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT) |-> !dir_wr);

    // R1
    state_legal_chk: assert property (@(posedge clk) disable iff (rst)
        state_q inside {ST_IDLE, ST_WAIT, ST_BEAT});

endmodule

// File: rtl/mlb_addr_ctr.sv
module mlb_addr_ctr
    import mlb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  logic      adv,
    input  mlb_word_t bus_word,
    output mlb_word_t addr
);

    always_ff @(posedge clk) begin
        if (rst)
            addr <= '0;
        else if (load)
            addr <= align_word(bus_word);
        else if (adv)
            addr <= next_word(addr);
    end

endmodule

// File: rtl/mlb_port.sv
module mlb_port
    import mlb_pkg::*;
(
    input  logic      beat,
    input  logic      dir_wr,
    input  mlb_word_t addr,
    input  mlb_word_t bus_word,
    input  mlb_lane_t be_n,
    input  mlb_word_t rdata,
    output mlb_req_t  req,
    output mlb_word_t ad_out,
    output logic      ad_oe
);

    logic rd_beat;
    logic wr_beat;

    assign wr_beat = beat && dir_wr;
    assign rd_beat = beat && !dir_wr;

    always_comb begin
        req.we    = wr_beat;
        req.re    = rd_beat;
        req.addr  = addr;
        req.wdata = bus_word;
        req.be    = wr_beat ? ~be_n : '0;
    end

    assign ad_oe  = rd_beat;
    assign ad_out = rd_beat ? rdata : '0;

endmodule

// File: rtl/mlb_target.sv
module mlb_target
    import mlb_pkg::*;
#(
    parameter int unsigned WAIT_RD = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MLB_DW-1:0] lb_ad_in,
    output logic [MLB_DW-1:0] lb_ad_out,
    output logic              lb_ad_oe,
    input  logic [MLB_BE-1:0] lb_be_n,
    input  logic              lb_strobe_n,
    input  logic              lb_last_n,
    input  logic              lb_write,
    output logic              lb_ready_n,
    output logic              mem_we,
    output logic              mem_re,
    output logic [MLB_DW-1:0] mem_addr,
    output logic [MLB_DW-1:0] mem_wdata,
    output logic [MLB_BE-1:0] mem_be,
    input  logic [MLB_DW-1:0] mem_rdata
);

    logic      load;
    logic      beat;
    logic      dir_wr;
    mlb_word_t cur_addr;
    mlb_req_t  req;

    mlb_seq #(.WAIT_RD(WAIT_RD)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .strobe_n (lb_strobe_n),
        .wr_dir   (lb_write),
        .last_n   (lb_last_n),
        .load     (load),
        .beat     (beat),
        .ready_n  (lb_ready_n),
        .dir_wr   (dir_wr)
    );

    mlb_addr_ctr u_addr (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .adv      (beat),
        .bus_word (lb_ad_in),
        .addr     (cur_addr)
    );

    mlb_port u_port (
        .beat     (beat),
        .dir_wr   (dir_wr),
        .addr     (cur_addr),
        .bus_word (lb_ad_in),
        .be_n     (lb_be_n),
        .rdata    (mem_rdata),
        .req      (req),
        .ad_out   (lb_ad_out),
        .ad_oe    (lb_ad_oe)
    );

    assign mem_we    = req.we;
    assign mem_re    = req.re;
    assign mem_addr  = req.addr;
    assign mem_wdata = req.wdata;
    assign mem_be    = req.be;

    // R5
    burst_end_chk: assert property (@(posedge clk) disable iff (rst)
        (!lb_ready_n && !lb_last_n) |=> lb_ready_n);

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!lb_ready_n && lb_last_n) |=> (mem_addr == $past(mem_addr) + MLB_DW'(MLB_BE)));

    // R7
    oe_beat_chk: assert property (@(posedge clk) disable iff (rst)
        lb_ad_oe |-> (!lb_ready_n && mem_re));

    // R3
    we_beat_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !lb_ready_n);

    // R8
    rw_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        lb_ready_n |-> !(mem_we || mem_re || lb_ad_oe));

endmodule

// File: tb/tb_mlb_target.sv
module tb_mlb_target;

    localparam int CLK_PERIOD = 10;
    localparam int WAIT_RD    = 2;

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  be;
    } wr_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] lb_ad_in = '0;
    logic [31:0] lb_ad_out;
    logic        lb_ad_oe;
    logic [3:0]  lb_be_n = 4'hF;
    logic        lb_strobe_n = 1'b1;
    logic        lb_last_n = 1'b1;
    logic        lb_write = 1'b0;
    logic        lb_ready_n;
    logic        mem_we, mem_re;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_be;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    logic [31:0] tbmem   [16];
    logic [31:0] ref_mem [16];
    wr_item_t    exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mlb_target #(.WAIT_RD(WAIT_RD)) dut (
        .clk(clk), .rst(rst),
        .lb_ad_in(lb_ad_in), .lb_ad_out(lb_ad_out), .lb_ad_oe(lb_ad_oe),
        .lb_be_n(lb_be_n), .lb_strobe_n(lb_strobe_n), .lb_last_n(lb_last_n),
        .lb_write(lb_write), .lb_ready_n(lb_ready_n),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] init_word(input int k);
        return 32'hC0DE_0000 + 32'(k * 32'h0111);
    endfunction

    // internal memory attached to the port
    assign mem_rdata = tbmem[mem_addr[5:2]];
    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 16; k++) tbmem[k] <= init_word(k);
        end else if (mem_we) begin
            for (int b = 0; b < 4; b++)
                if (mem_be[b]) tbmem[mem_addr[5:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops expected write items as the port produces them
    always @(negedge clk) begin
        #2;
        if (!rst && mem_we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected write", mem_addr, 32'h0);
            end else begin
                wr_item_t e;
                e = exp_q.pop_front();
                check(mem_addr == e.addr, "R4 write address", mem_addr, e.addr);
                check(mem_wdata == e.data, "R3 write data", mem_wdata, e.data);
                check(mem_be == e.be, "R3 lane mask", {28'h0, mem_be}, {28'h0, e.be});
            end
        end
    end

    task automatic addr_cycle(input logic [31:0] a, input logic wr);
        @(negedge clk);
        lb_strobe_n = 1'b0;
        lb_ad_in    = a;
        lb_write    = wr;
        lb_last_n   = 1'b1;
        lb_be_n     = 4'hF;
        #1;
        check(lb_ready_n == 1'b1, "R7 ready high in address cycle", {31'h0, lb_ready_n}, 32'h1);
        check(lb_ad_oe == 1'b0, "R7 bus released in address cycle", {31'h0, lb_ad_oe}, 32'h0);
        @(posedge clk);
    endtask

    // returns number of wait cycles before ready
    task automatic wait_ready(output int waits);
        waits = 0;
        #1;
        while (lb_ready_n && waits < 40) begin
            if (lb_ad_oe) check(1'b0, "R7 bus driven while waiting", 32'h1, 32'h0);
            waits++;
            @(posedge clk);
            @(negedge clk);
            #1;
        end
    endtask

    task automatic end_check();
        @(negedge clk);
        lb_strobe_n = 1'b1;
        lb_last_n   = 1'b1;
        lb_ad_in    = 32'hDEAD_BEEF;
        #1;
        check(lb_ready_n == 1'b1, "R5 idle after last beat", {31'h0, lb_ready_n}, 32'h1);
        check(lb_ad_oe == 1'b0, "R7 released after last beat", {31'h0, lb_ad_oe}, 32'h0);
    endtask

    task automatic do_write(input logic [31:0] start, input int n, input logic [31:0] base,
                            input logic [3:0] be_n, input int stray_at);
        logic [31:0] a;
        a = {start[31:2], 2'b00};
        addr_cycle(start, 1'b1);
        for (int i = 0; i < n; i++) begin
            int w;
            wr_item_t e;
            logic [31:0] d;
            @(negedge clk);
            d = base + 32'(i) * 32'h0101_0101;
            lb_strobe_n = (i == stray_at) ? 1'b0 : 1'b1; // R9 stray strobe
            lb_ad_in    = d;
            lb_be_n     = be_n;
            lb_last_n   = (i == n - 1) ? 1'b0 : 1'b1;
            e.addr = a; e.data = d; e.be = ~be_n;
            exp_q.push_back(e);
            wait_ready(w);
            check(w == 0, "R6 no write wait", 32'(w), 32'h0);
            check(lb_ad_oe == 1'b0, "R7 bus released on write", {31'h0, lb_ad_oe}, 32'h0);
            for (int b = 0; b < 4; b++)
                if (!be_n[b]) ref_mem[a[5:2]][8*b +: 8] = d[8*b +: 8];
            @(posedge clk);
            a = a + 32'd4;
        end
        end_check();
    endtask

    task automatic do_read(input logic [31:0] start, input int n);
        logic [31:0] a;
        a = {start[31:2], 2'b00};
        addr_cycle(start, 1'b0);
        for (int i = 0; i < n; i++) begin
            int w;
            @(negedge clk);
            lb_strobe_n = 1'b1;
            lb_ad_in    = '0;
            lb_be_n     = 4'h0;
            lb_last_n   = (i == n - 1) ? 1'b0 : 1'b1;
            wait_ready(w);
            check(w == ((i == 0) ? WAIT_RD : 0), "R6 read wait count", 32'(w), 32'((i == 0) ? WAIT_RD : 0));
            check(lb_ad_oe == 1'b1, "R7 bus driven in read beat", {31'h0, lb_ad_oe}, 32'h1);
            check(mem_re == 1'b1, "R8 internal read strobe", {31'h0, mem_re}, 32'h1);
            check(lb_ad_out == ref_mem[a[5:2]], "R8 read data", lb_ad_out, ref_mem[a[5:2]]);
            @(posedge clk);
            a = a + 32'd4;
        end
        end_check();
    endtask

    initial begin
        for (int k = 0; k < 16; k++) ref_mem[k] = init_word(k);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check(lb_ready_n == 1'b1, "R1 ready after reset", {31'h0, lb_ready_n}, 32'h1);
        check(lb_ad_oe == 1'b0, "R1 oe after reset", {31'h0, lb_ad_oe}, 32'h0);
        check(!mem_we && !mem_re, "R1 no request after reset", {30'h0, mem_we, mem_re}, 32'h0);

        // R2 idle bus noise starts nothing
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            lb_ad_in  = 32'h1234_5678 ^ 32'(i);
            lb_write  = i[0];
            lb_last_n = i[1];
            #1;
            check(lb_ready_n && !mem_we && !mem_re, "R2 idle ignores bus", {29'h0, lb_ready_n, mem_we, mem_re}, 32'h4);
        end
        lb_last_n = 1'b1;

        do_write(32'h0000_0004, 1, 32'hAABB_CCDD, 4'h0, -1);        // R3 single word
        do_write(32'h0000_0012, 4, 32'h1020_3040, 4'b1010, -1);     // R2 alignment, R3 partial lanes
        do_write(32'h0000_0030, 5, 32'h5500_0011, 4'h0, 2);         // R9 stray strobe, R4 wrap
        do_read(32'h0000_0004, 1);                                  // R6 R8 single read
        do_read(32'h0000_0011, 4);                                  // R8 masked data readback
        do_read(32'h0000_0033, 5);                                  // R4 R9 continuation
        do_read(32'h0000_0020, 3);                                  // R8 untouched words

        repeat (3) @(posedge clk);
        check(exp_q.size() == 0, "R3 all writes seen", 32'(exp_q.size()), 32'h0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule